// File: doc/BRIEF.md
# Trapping Integer ALU

This block is the arithmetic and logic stage of a small 32-bit RISC core. It is purely combinational. A core feeds it two register operands, a 5-bit shift count, the 16-bit immediate field of the instruction and an operation code. It returns the result word in the same cycle. It also returns a trap flag for signed overflow and a matching write-cancel line, which the core uses to drop the register write of a trapping instruction.

Add and subtract each come in two kinds. The trapping kind flags signed two's-complement overflow, and the wrapping kind never flags it. The block widens the immediate itself: arithmetic and compare forms sign-extend it, and the logical forms zero-extend it. Both set-less-than comparisons and both subtractions run through one shared adder. The shifts use a logarithmic barrel network. There are no states. The decoder turns each code into a control bundle, and the named result paths are arithmetic, and, or, nor, signed less, unsigned less, left shift, right shift, upper immediate and zero.

Top module: `int_alu_trap`

## Requirements
- R1: The 5-bit operation code is decoded as follows: 0 add, 1 addu, 2 sub, 3 subu, 4 addi, 5 addiu, 6 and, 7 andi, 8 or, 9 ori, 10 nor, 11 slt, 12 sltu, 13 slti, 14 sltiu, 15 sll, 16 srl, 17 lui. Add, addu, sub and subu return A+B or A-B modulo 2^32.
- R2: Add (0), sub (2) and addi (4) raise the trap output whenever the true signed result falls outside the 32-bit two's-complement range.
- R3: Addu (1), subu (3) and addiu (5) never raise the trap output.
- R4: Addi, addiu, slti and sltiu use the immediate widened with 16 copies of its bit 15 in place of operand B. For every immediate form, operand B has no effect on any output.
- R5: Andi and ori use the immediate with 16 zero bits above it in place of operand B.
- R6: And, or and nor return A&B, A|B and ~(A|B).
- R7: Slt and slti compare A with the second operand as signed values. The result is 1 when A is less and 0 otherwise.
- R8: Sltu compares as unsigned. Sltiu sign-extends the immediate and then compares as unsigned. Both return 1 or 0.
- R9: Sll and srl shift operand A by the 5-bit shift count. Srl fills with zeros from the top.
- R10: Lui returns the immediate in bits 31:16 and zeros in bits 15:0.
- R11: The write-cancel output equals the trap output. On a trap the result output still carries the wrapped sum or difference.
- R12: Codes 18 to 31 return a zero result, with trap and write-cancel both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register forms) |
| shamt | input | 5 | Shift count |
| imm16 | input | 16 | Instruction immediate field |
| op_sel | input | 5 | Operation code |
| result | output | 32 | Result word |
| ovf_trap | output | 1 | Signed overflow of a trapping form |
| wr_suppress | output | 1 | Cancel the register write |

## Verification
Every one of the 32 operation codes is tried against the cross product of a corner operand set. That set holds 0, 1, the largest and smallest signed values, all ones, and two mixed words. Its extremes tell signed overflow apart from unsigned carry, and they tell signed from unsigned ordering. Immediates of 0x7FFF, 0x8000 and 0xFFFF separate sign from zero extension, and the full range of operand B values shows that the immediate forms ignore B. A sweep of all 32 shift counts over several words catches missing barrel stages and wrong fill bits. The upper codes confirm the zero default.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,
        OP_ADDIU = 5'd5,
        OP_AND   = 5'd6,
        OP_ANDI  = 5'd7,
        OP_OR    = 5'd8,
        OP_ORI   = 5'd9,
        OP_NOR   = 5'd10,
        OP_SLT   = 5'd11,
        OP_SLTU  = 5'd12,
        OP_SLTI  = 5'd13,
        OP_SLTIU = 5'd14,
        OP_SLL   = 5'd15,
        OP_SRL   = 5'd16,
        OP_LUI   = 5'd17
    } alu_op_e;

    localparam logic [4:0] OP_LAST = 5'd17;

    typedef enum logic [3:0] {
        SEL_ZERO,
        SEL_ARITH,
        SEL_AND,
        SEL_OR,
        SEL_NOR,
        SEL_SLT,
        SEL_SLTU,
        SEL_SLL,
        SEL_SRL,
        SEL_LUI
    } res_sel_e;

    typedef struct packed {
        logic     use_imm;
        logic     imm_sext;
        logic     do_sub;
        logic     trap_en;
        res_sel_e sel;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [4:0] op_sel,
    output alu_ctrl_t  ctrl
);

    always_comb begin
        ctrl = '{use_imm: 1'b0, imm_sext: 1'b0, do_sub: 1'b0,
                 trap_en: 1'b0, sel: SEL_ZERO};
        case (op_sel)
            OP_ADD:   begin ctrl.sel = SEL_ARITH; ctrl.trap_en = 1'b1; end
            OP_ADDU:  begin ctrl.sel = SEL_ARITH; end
            OP_SUB:   begin ctrl.sel = SEL_ARITH; ctrl.do_sub = 1'b1; ctrl.trap_en = 1'b1; end
            OP_SUBU:  begin ctrl.sel = SEL_ARITH; ctrl.do_sub = 1'b1; end
            OP_ADDI:  begin ctrl.sel = SEL_ARITH; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.trap_en = 1'b1; end
            OP_ADDIU: begin ctrl.sel = SEL_ARITH; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; end
            OP_AND:   begin ctrl.sel = SEL_AND; end
            OP_ANDI:  begin ctrl.sel = SEL_AND; ctrl.use_imm = 1'b1; end
            OP_OR:    begin ctrl.sel = SEL_OR; end
            OP_ORI:   begin ctrl.sel = SEL_OR; ctrl.use_imm = 1'b1; end
            OP_NOR:   begin ctrl.sel = SEL_NOR; end
            OP_SLT:   begin ctrl.sel = SEL_SLT; ctrl.do_sub = 1'b1; end
            OP_SLTU:  begin ctrl.sel = SEL_SLTU; ctrl.do_sub = 1'b1; end
            OP_SLTI:  begin ctrl.sel = SEL_SLT; ctrl.do_sub = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; end
            OP_SLTIU: begin ctrl.sel = SEL_SLTU; ctrl.do_sub = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; end
            OP_SLL:   begin ctrl.sel = SEL_SLL; end
            OP_SRL:   begin ctrl.sel = SEL_SRL; end
            OP_LUI:   begin ctrl.sel = SEL_LUI; ctrl.use_imm = 1'b1; end
            default:  begin ctrl.sel = SEL_ZERO; end
        endcase
    end

endmodule

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    output logic [DATA_W-1:0] ext
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic fill;
    assign fill = sext & imm[IMM_W-1];

    generate
        if (PAD_W > 0) begin : g_pad
            assign ext = {{PAD_W{fill}}, imm};
        end else begin : g_nopad
            assign ext = imm[DATA_W-1:0];
        end
    endgenerate

    // R4 / R5: the upper bits are either all copies of bit 15 or all zero
    always_comb begin
        if (PAD_W > 0 && !sext) begin
            p_zext_r5: assert (ext[DATA_W-1] == 1'b0)
                else $error("zero extension left a set top bit");
        end
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf,
    output logic              lt_s,
    output logic              lt_u
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              carry;

    assign b_eff          = sub ? ~b : b;
    assign {carry, sum}   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    assign ovf            = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    assign lt_s           = sum[MSB] ^ ovf;
    assign lt_u           = ~carry;

    always_comb begin
        if (sub) begin
            p_lt_signed_r7: assert (lt_s == ($signed(a) < $signed(b)))
                else $error("signed less-than from the adder disagrees");
            p_lt_unsigned_r8: assert (lt_u == (a < b))
                else $error("unsigned less-than from the borrow disagrees");
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  sll_out,
    output logic [DATA_W-1:0]  srl_out
);

    logic [DATA_W-1:0] lst [0:SHAMT_W];
    logic [DATA_W-1:0] rst [0:SHAMT_W];

    assign lst[0] = din;
    assign rst[0] = din;

    generate
        for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
            localparam int STEP = 1 << i;
            assign lst[i+1] = shamt[i] ? {lst[i][DATA_W-1-STEP:0], {STEP{1'b0}}} : lst[i];
            assign rst[i+1] = shamt[i] ? {{STEP{1'b0}}, rst[i][DATA_W-1:STEP]} : rst[i];
        end
    endgenerate

    assign sll_out = lst[SHAMT_W];
    assign srl_out = rst[SHAMT_W];

    // R9: a nonzero shift brings a zero into the vacated end bit
    always_comb begin
        if (shamt != '0) begin
            p_fill_r9: assert (sll_out[0] == 1'b0 && srl_out[DATA_W-1] == 1'b0)
                else $error("shift did not fill with zero");
        end
    end

endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
    import alu_pkg::*;
#(
    parameter int  DATA_W  = 32,
    parameter int  IMM_W   = 16,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [IMM_W-1:0]   imm16,
    input  logic [4:0]         op_sel,
    output logic [DATA_W-1:0]  result,
    output logic               ovf_trap,
    output logic               wr_suppress
);

    localparam int LOW_W = DATA_W - IMM_W;

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_y;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_ovf;
    logic              less_s;
    logic              less_u;
    logic [DATA_W-1:0] shl_val;
    logic [DATA_W-1:0] shr_val;
    logic [DATA_W-1:0] upper_val;

    alu_decode u_dec (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm  (imm16),
        .sext (ctrl.imm_sext),
        .ext  (imm_ext)
    );

    assign opnd_y = ctrl.use_imm ? imm_ext : opnd_b;

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (opnd_a),
        .b    (opnd_y),
        .sub  (ctrl.do_sub),
        .sum  (arith_sum),
        .ovf  (arith_ovf),
        .lt_s (less_s),
        .lt_u (less_u)
    );

    alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .din     (opnd_a),
        .shamt   (shamt),
        .sll_out (shl_val),
        .srl_out (shr_val)
    );

    generate
        if (LOW_W > 0) begin : g_upper
            assign upper_val = {imm16, {LOW_W{1'b0}}};
        end else begin : g_upper_full
            assign upper_val = imm16[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (ctrl.sel)
            SEL_ARITH: result = arith_sum;
            SEL_AND:   result = opnd_a & opnd_y;
            SEL_OR:    result = opnd_a | opnd_y;
            SEL_NOR:   result = ~(opnd_a | opnd_y);
            SEL_SLT:   result = {{(DATA_W-1){1'b0}}, less_s};
            SEL_SLTU:  result = {{(DATA_W-1){1'b0}}, less_u};
            SEL_SLL:   result = shl_val;
            SEL_SRL:   result = shr_val;
            SEL_LUI:   result = upper_val;
            default:   result = '0;
        endcase
    end

    assign ovf_trap    = ctrl.trap_en & arith_ovf;
    assign wr_suppress = ovf_trap;

    always_comb begin
        if (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU) begin
            p_no_overflow_r3: assert (!ovf_trap)
                else $error("wrapping form raised the trap");
        end
        if (ovf_trap) begin
            p_kept_result_r11: assert (result[DATA_W-1] != opnd_a[DATA_W-1])
                else $error("trapped result is not the wrapped value");
        end
        if (op_sel > OP_LAST) begin
            p_unknown_zero_r12: assert (result == '0 && !ovf_trap && !wr_suppress)
                else $error("unknown code produced output");
        end
        if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU) begin
            p_bool_result_r7: assert (result[DATA_W-1:1] == '0)
                else $error("compare result is not 0 or 1");
        end
        if (op_sel == OP_LUI) begin
            p_lui_low_r10: assert (result[IMM_W-1:0] == '0 || LOW_W < IMM_W)
                else $error("upper-immediate low half not zero");
        end
    end

endmodule

// File: tb/sim_int_alu_trap.sv
`timescale 1ns/1ps
module sim_int_alu_trap;

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  op_sel = 5'd31;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_suppress;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_alu_trap u0 (
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .shamt       (shamt),
        .imm16       (imm16),
        .op_sel      (op_sel),
        .result      (result),
        .ovf_trap    (ovf_trap),
        .wr_suppress (wr_suppress)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 2, 4:        return "R2";
            1, 3, 5:        return "R3";
            6, 8, 10:       return "R6";
            7, 9:           return "R5";
            11, 13:         return "R7";
            12, 14:         return "R8";
            15, 16:         return "R9";
            17:             return "R10";
            default:        return "R12";
        endcase
    endfunction

    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [15:0] im,
                         output logic [31:0] er, output logic ev);
        logic [31:0] sx;
        logic [31:0] zx;
        longint      wide;
        sx = {{16{im[15]}}, im};
        zx = {16'h0000, im};
        er = '0;
        ev = 1'b0;
        case (op)
            0, 1: begin
                er = a + b;
                wide = longint'($signed(a)) + longint'($signed(b));
                ev = (op == 0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
            end
            2, 3: begin
                er = a - b;
                wide = longint'($signed(a)) - longint'($signed(b));
                ev = (op == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
            end
            4, 5: begin
                er = a + sx;
                wide = longint'($signed(a)) + longint'($signed(sx));
                ev = (op == 4) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
            end
            6:  er = a & b;
            7:  er = a & zx;
            8:  er = a | b;
            9:  er = a | zx;
            10: er = ~(a | b);
            11: er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            12: er = (a < b) ? 32'd1 : 32'd0;
            13: er = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            14: er = (a < sx) ? 32'd1 : 32'd0;
            15: er = a << sh;
            16: er = a >> sh;
            17: er = {im, 16'h0000};
            default: er = '0;
        endcase
    endtask

    task automatic run(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic [15:0] im, input string tag);
        logic [31:0] er;
        logic        ev;
        @(posedge clk);
        op_sel = 5'(op);
        opnd_a = a;
        opnd_b = b;
        shamt  = sh;
        imm16  = im;
        model(op, a, b, sh, im, er, ev);
        @(negedge clk);
        n_checks++;
        if (result !== er || ovf_trap !== ev || wr_suppress !== ev) begin
            n_fails++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d imm=%h : actual r=%h v=%b s=%b expected r=%h v=%b s=%b",
                     tag, op, a, b, sh, im, result, ovf_trap, wr_suppress, er, ev, ev);
        end
    endtask

    logic [31:0] vals [8];
    logic [15:0] imms [6];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'hFFFF_FFFF; vals[5] = 32'hFFFF_FFFE;
        vals[6] = 32'h1234_5678; vals[7] = 32'h8000_0001;
        imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h7FFF;
        imms[3] = 16'h8000; imms[4] = 16'hFFFF; imms[5] = 16'h1234;

        // idle state: an unused code with all-zero data gives zero (R12)
        run(31, '0, '0, '0, '0, "R12");

        // directed boundaries
        run(0, 32'h7FFF_FFFF, 32'h1, 5'd0, 16'h0, "R2 add max+1");
        run(2, 32'h8000_0000, 32'h1, 5'd0, 16'h0, "R2 sub min-1");
        run(4, 32'h7FFF_FFFF, 32'h0, 5'd0, 16'h0001, "R2 addi");
        run(1, 32'h7FFF_FFFF, 32'h1, 5'd0, 16'h0, "R3 addu");
        run(0, 32'h7FFF_FFF0, 32'h20, 5'd0, 16'h0, "R11 wrapped result kept");
        run(14, 32'h0000_0005, 32'h0, 5'd0, 16'hFFFF, "R8 sltiu sext");
        run(13, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'h0000, "R7 slti");
        run(7, 32'hFFFF_FFFF, 32'h0, 5'd0, 16'h8001, "R5 andi");
        run(17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 16'hBEEF, "R10 lui");

        // cross product sweep over all codes
        for (int op = 0; op < 32; op++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    run(op, vals[ia], vals[ib], 5'((ia * 5 + ib * 3) % 32),
                        imms[(ia + ib) % 6], (op <= 3) ? "R1" : req_of(op));
                end
            end
        end

        // immediate forms ignore operand B (R4)
        for (int op = 4; op < 18; op++) begin
            if (op == 4 || op == 5 || op == 7 || op == 9 || op == 13 || op == 14 || op == 17) begin
                for (int ib = 0; ib < 8; ib++) begin
                    for (int ii = 0; ii < 6; ii++) begin
                        run(op, vals[6], vals[ib], 5'd3, imms[ii], "R4");
                    end
                end
            end
        end

        // full shift-count sweep (R9)
        for (int sh = 0; sh < 32; sh++) begin
            for (int ia = 2; ia < 8; ia++) begin
                run(15, vals[ia], 32'h0, 5'(sh), 16'h0, "R9 sll");
                run(16, vals[ia], 32'h0, 5'(sh), 16'h0, "R9 srl");
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule